// File: doc/BRIEF.md
# Recursive Moving-Average Filter

This block smooths a stream of unsigned ADC samples by producing, for every accepted sample, the sum of the most recent window of samples. It does not add up the whole window each time. It keeps a running integrator of every sample seen since reset, and it keeps a short history of past integrator values. The window sum is the newest integrator value minus the value from one window length earlier. The integrator and history use a wider internal word. Each sample is placed in the upper bits of that word, with a few zero guard bits below it.

A source presents a sample together with a valid strobe. One clock later the block presents the window sum with its own valid strobe, and it holds that result until the next sample arrives. The window length is a parameter with a minimum of 2. The result is the raw window sum: it is not divided by the window length.

Top module: `mavg_boxcar`

## Requirements
- R1: Each incoming sample of SAMPLE_W bits (default 24) occupies the upper bits of an internal word of SAMPLE_W+GUARD_W bits (default 28), with the lowest GUARD_W bits (default 4) at zero. The sample is therefore scaled by 2^GUARD_W, and a single sample after reset comes out unchanged on `out_sum`.
- R2: The integrator adds the widened sample on every clock with `in_valid` high and keeps its value on every other clock.
- R3: The internal difference is the newest integrator value minus the integrator value from WINDOW accepted samples earlier. `out_sum` is bits [SAMPLE_W+GUARD_W-1:GUARD_W] of that difference, which equals the sum of the last WINDOW accepted samples modulo 2^SAMPLE_W.
- R4: After reset the history reads as zero, so for the first WINDOW samples `out_sum` is the sum of only the samples accepted since reset.
- R5: All internal additions and subtractions wrap modulo 2^(SAMPLE_W+GUARD_W). `out_sum` stays correct after the integrator has wrapped, including for runs of full-scale samples.
- R6: `out_valid` is high in exactly the clock that follows a clock with `in_valid` high, and the new `out_sum` appears in that same clock.
- R7: While `in_valid` is low, `in_sample` is ignored, `out_sum` holds its last value and the history does not advance.
- R8: A synchronous active-high `rst` clears the integrator, the history, `out_valid` and `out_sum` to zero, including during a running stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when `in_sample` carries a sample to accept |
| in_sample | input | SAMPLE_W | Unsigned input sample |
| out_valid | output | 1 | High for one clock after each accepted sample |
| out_sum | output | SAMPLE_W | Window sum of the last WINDOW samples, modulo 2^SAMPLE_W |

## Verification
The bench drives a window of 4 with several patterns. A single impulse followed by zeros shows that a sample leaves the sum after exactly WINDOW further samples. A rising ramp shows the partial sums during fill-up and then the steady sliding behaviour. Long runs of full-scale samples wrap the integrator on almost every step, which separates correct modular arithmetic from arithmetic that saturates or drops bits. Gaps with `in_valid` low while the sample lines change, and a reset in the middle of a stream, show that the history advances only on accepted samples and that reset clears it.

// File: rtl/mavg_pkg.sv
package mavg_pkg;

  // Default geometry of the filter datapath.
  localparam int unsigned SAMPLE_W_DEF = 24;
  localparam int unsigned GUARD_W_DEF  = 4;
  localparam int unsigned WINDOW_DEF   = 8;

  // Word width of the integrator and history for a given geometry.
  function automatic int unsigned word_width(input int unsigned sample_w,
                                             input int unsigned guard_w);
    return sample_w + guard_w;
  endfunction

endpackage

// File: rtl/mavg_widen.sv
module mavg_widen
  import mavg_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
  parameter int unsigned GUARD_W  = GUARD_W_DEF,
  localparam int unsigned WORD_W  = SAMPLE_W + GUARD_W
) (
  input  logic [SAMPLE_W-1:0] sample,
  output logic [WORD_W-1:0]   word
);

  // The sample goes into the top bits; the guard bits below it stay at zero.
  always_comb begin
    word = {sample, {GUARD_W{1'b0}}};
  end

endmodule

// File: rtl/mavg_integrator.sv
module mavg_integrator
  import mavg_pkg::*;
#(
  parameter int unsigned WORD_W = word_width(SAMPLE_W_DEF, GUARD_W_DEF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [WORD_W-1:0] addend,
  output logic [WORD_W-1:0] sum_next,
  output logic [WORD_W-1:0] sum_q
);

  // Running sum; the width drops any carry, so it wraps modulo 2^WORD_W.
  always_comb begin
    sum_next = sum_q + addend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
    end else if (en) begin
      sum_q <= sum_next;
    end
  end

  // R2: the integrator keeps its value on clocks without a sample
  assert_integrator_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(sum_q));

  // R2: on a sample, the integrator grows by exactly the widened sample
  assert_integrator_step_R2: assert property (@(posedge clk) disable iff (rst)
    en |=> (sum_q - $past(sum_q)) == $past(addend));

endmodule

// File: rtl/mavg_delay_line.sv
module mavg_delay_line
  import mavg_pkg::*;
#(
  parameter int unsigned WORD_W = word_width(SAMPLE_W_DEF, GUARD_W_DEF),
  parameter int unsigned DEPTH  = WINDOW_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] oldest
);

  logic [WORD_W-1:0] stage [DEPTH];

  // Stage 0 takes the new value; every later stage takes its neighbour's.
  // Nothing moves unless a sample is accepted.
  always_ff @(posedge clk) begin
    if (rst) begin
      stage[0] <= '0;
    end else if (shift) begin
      stage[0] <= din;
    end
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage[g] <= '0;
      end else if (shift) begin
        stage[g] <= stage[g-1];
      end
    end
  end

  assign oldest = stage[DEPTH-1];

  // R7: the history does not advance on idle clocks
  assert_history_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !shift |=> $stable(oldest));

  // R3: an accepted value enters the head of the history
  assert_history_load_R3: assert property (@(posedge clk) disable iff (rst)
    shift |=> stage[0] == $past(din));

endmodule

// File: rtl/mavg_comb_out.sv
module mavg_comb_out
  import mavg_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
  parameter int unsigned GUARD_W  = GUARD_W_DEF,
  localparam int unsigned WORD_W  = SAMPLE_W + GUARD_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                take,
  input  logic [WORD_W-1:0]   newest,
  input  logic [WORD_W-1:0]   delayed,
  output logic                valid_q,
  output logic [SAMPLE_W-1:0] sum_q
);

  logic [WORD_W-1:0] diff;

  // Wrapping difference; the window sum is exact while it fits in WORD_W.
  always_comb begin
    diff = newest - delayed;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      sum_q   <= '0;
    end else begin
      valid_q <= take;
      if (take) begin
        sum_q <= diff[WORD_W-1:GUARD_W];
      end
    end
  end

  // R1: both operands come from zero-guarded words, so the guard bits of
  // the difference stay zero and the upper slice drops nothing
  assert_guard_bits_zero_R1: assert property (@(posedge clk) disable iff (rst)
    take |-> diff[GUARD_W-1:0] == '0);

endmodule

// File: rtl/mavg_boxcar.sv
module mavg_boxcar
  import mavg_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
  parameter int unsigned GUARD_W  = GUARD_W_DEF,
  parameter int unsigned WINDOW   = WINDOW_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_sum
);

  localparam int unsigned WORD_W = word_width(SAMPLE_W, GUARD_W);

  if (WINDOW < 2) begin : g_bad_window
    $error("mavg_boxcar: WINDOW must be at least 2");
  end

  logic [WORD_W-1:0] wide_sample;
  logic [WORD_W-1:0] integ_next;
  logic [WORD_W-1:0] integ_q;
  logic [WORD_W-1:0] integ_old;

  mavg_widen #(
    .SAMPLE_W (SAMPLE_W),
    .GUARD_W  (GUARD_W)
  ) u_widen (
    .sample (in_sample),
    .word   (wide_sample)
  );

  mavg_integrator #(
    .WORD_W (WORD_W)
  ) u_integ (
    .clk      (clk),
    .rst      (rst),
    .en       (in_valid),
    .addend   (wide_sample),
    .sum_next (integ_next),
    .sum_q    (integ_q)
  );

  // Holds the last WINDOW integrator values; the oldest one is the value
  // from WINDOW samples before the one being accepted now.
  mavg_delay_line #(
    .WORD_W (WORD_W),
    .DEPTH  (WINDOW)
  ) u_hist (
    .clk    (clk),
    .rst    (rst),
    .shift  (in_valid),
    .din    (integ_next),
    .oldest (integ_old)
  );

  mavg_comb_out #(
    .SAMPLE_W (SAMPLE_W),
    .GUARD_W  (GUARD_W)
  ) u_out (
    .clk     (clk),
    .rst     (rst),
    .take    (in_valid),
    .newest  (integ_next),
    .delayed (integ_old),
    .valid_q (out_valid),
    .sum_q   (out_sum)
  );

  // R6: a result follows each accepted sample by one clock
  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R6: no result without a sample one clock earlier
  assert_valid_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R7: the result holds between samples
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_sum));

  // R2: the integrator moves only with accepted samples
  assert_integ_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(integ_q));

endmodule

// File: tb/test_mavg_boxcar.sv
module test_mavg_boxcar;

  localparam int unsigned SW  = 24;
  localparam int unsigned GW  = 4;
  localparam int unsigned WIN = 4;
  localparam logic [SW-1:0] FULL = {SW{1'b1}};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [SW-1:0] in_sample = '0;
  logic          out_valid;
  logic [SW-1:0] out_sum;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Model: last WIN accepted samples, newest at index 0
  logic [SW-1:0] hist [WIN];
  logic [SW-1:0] last_out = '0;

  always #5 clk = ~clk;

  mavg_boxcar #(
    .SAMPLE_W (SW),
    .GUARD_W  (GW),
    .WINDOW   (WIN)
  ) i_mavg_boxcar (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .out_valid (out_valid),
    .out_sum   (out_sum)
  );

  task automatic check(input string req, input logic [SW-1:0] act,
                       input logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < WIN; i++) hist[i] = '0;
    last_out = '0;
  endtask

  function automatic logic [SW-1:0] model_sum();
    logic [SW-1:0] s = '0;
    for (int i = 0; i < WIN; i++) s = s + hist[i];
    return s;
  endfunction

  // Drive one sample at a falling edge, check after the next rising edge.
  task automatic push(input logic [SW-1:0] v, input string req);
    in_valid  = 1'b1;
    in_sample = v;
    for (int i = WIN - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = v;
    last_out = model_sum();
    @(negedge clk);
    check({req, " valid"}, {{(SW-1){1'b0}}, out_valid}, 1);
    check(req, out_sum, last_out);
    in_valid = 1'b0;
  endtask

  // Idle clocks with changing sample lines; output must hold.
  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      in_valid  = 1'b0;
      in_sample = SW'(32'h00A5_5A00 + i * 977);
      @(negedge clk);
      check({req, " no valid"}, {{(SW-1){1'b0}}, out_valid}, 0);
      check({req, " hold"}, out_sum, last_out);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  initial begin
    model_clear();
    @(negedge clk);
    @(negedge clk);
    // R8: reset state
    check("R8 reset valid", {{(SW-1){1'b0}}, out_valid}, 0);
    check("R8 reset sum", out_sum, 0);
    rst = 1'b0;

    // R1: one sample after reset comes out unscaled
    push(24'h123456, "R1 single sample");
    idle(2, "R7");

    // R4/R3: impulse then zeros; leaves after WIN samples
    do_reset();
    push(24'd1000, "R4 impulse");
    for (int i = 0; i < WIN + 2; i++) push('0, "R3 impulse tail");

    // R4/R3: ramp fill-up and sliding
    do_reset();
    for (int i = 1; i <= 12; i++) push(SW'(i * 3001), "R3 ramp");

    // R6: back-to-back samples keep out_valid high each clock
    for (int i = 0; i < 6; i++) push(SW'(i * 65537 + 7), "R6 back-to-back");

    // R7: gaps between samples
    for (int i = 0; i < 8; i++) begin
      push(SW'(i * 123457), "R7 gapped");
      idle(i % 3 + 1, "R7 gap");
    end

    // R5: full-scale runs wrap the integrator
    for (int i = 0; i < 20; i++) push(FULL, "R5 full scale");
    for (int i = 0; i < 10; i++) push((i % 2) ? FULL : SW'(i * 4099), "R5 mixed");

    // R8: reset in the middle of a stream clears history
    push(24'hABCDEF, "R3 pre-reset");
    do_reset();
    check("R8 mid reset valid", {{(SW-1){1'b0}}, out_valid}, 0);
    check("R8 mid reset sum", out_sum, 0);
    push(24'h000042, "R8 first after reset");
    push(24'h000010, "R4 second after reset");

    // Sweep a small set of values through the window
    for (int a = 0; a < 16; a++) push(SW'(a * 1048573), "R3 sweep");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule